// File: doc/BRIEF.md
# Byte-wide EEPROM page-write controller

This block holds the control logic of a byte-wide parallel EEPROM behind an asynchronous static-RAM-style pin set: active-low chip enable, output enable and write enable, an address bus and an 8-bit data bus. All pins are sampled on the system clock. A falling write enable while chip enable is low is a write strobe. Strobes collect up to one page of 2^PAGE_W bytes into a page buffer. When no new strobe arrives for LOAD_TIMEOUT cycles, a self-timed commit of WRITE_CYCLES cycles copies the buffered bytes into the storage array. During that time, reads return a status byte instead of array data. The array has 2^ADDR_W bytes. That is 8192 at ADDR_W = 13; the default build uses 11 to keep elaboration small.

A write lock guards the array against stray writes. A three-strobe arming prefix at fixed address/data pairs turns the lock on. A six-strobe release sequence turns it off. While the lock is on, a load phase is committed only when the arming prefix leads it. The prefix bytes are never stored. A locked phase without the prefix still runs the full timed cycle and leaves the array unchanged.

The controller FSM has three states. IDLE moves to LOAD on the first strobe (transition *phase_open*). LOAD stays in LOAD on every further strobe, which restarts the byte timer (*byte_reload*). LOAD moves to PROGRAM when the byte timer expires (*load_expire*). PROGRAM moves back to IDLE after WRITE_CYCLES cycles (*commit_done*). The prefix tracker has seven steps. These are SQ_IDLE, then SQ_GOT1 and SQ_GOT2 (the common prefix), then SQ_GOT3, SQ_GOT4 and SQ_GOT5 (the release tail), and SQ_DATA. SQ_DATA is reached on a completed command (*arm_hit*, *release_hit*) or on the first byte that breaks the pattern (*abandon*). WRITE_CYCLES must be at least 2^PAGE_W, and ADDR_W at most 13.

Top module: `eepc_ctrl`

## Requirements
- R1: With ce_n and oe_n low and we_n high while not committing, dq_oe is high and dq_out holds mem[addr] one clock after the pins are sampled.
- R2: Each data strobe stores din at page-buffer offset addr[PAGE_W-1:0]. A data byte whose page field addr[ADDR_W-1:PAGE_W] differs from the first data byte of the phase is dropped.
- R3: A load phase ends LOAD_TIMEOUT cycles after its last strobe, and each strobe restarts that count. The commit then lasts WRITE_CYCLES cycles, and strobes during it change nothing.
- R4: During the commit, a read returns a status byte. Its bit 7 is the inverse of bit 7 of the last data byte. Its bit 6 starts at 0 and flips at the end of each read. Its bits 5..0 are bits 5..0 of that last data byte.
- R5: The arming prefix is three strobes: A1/0xAA, A2/0x55, A1/0xA0, with A1 = 0x1555 and A2 = 0x0AAA cut to ADDR_W bits (0x555 and 0x2AA at the default). It sets the lock at the end of its commit, and data bytes after it in the same phase are written.
- R6: While locked, a phase without the arming prefix runs the timed cycle, leaves the array unchanged and leaves the lock set.
- R7: The release sequence A1/0xAA, A2/0x55, A1/0x80, A1/0xAA, A2/0x55, A1/0x20 clears the lock at the end of its commit.
- R8: Command bytes are never stored, and their addresses take ordinary data in later phases.
- R9: If a phase starts like a command and then breaks the pattern, the earlier prefix bytes are dropped and the breaking byte is stored as the first data byte.
- R10: Reset leaves the controller idle and unlocked with dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a falling edge is a strobe |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | High when dq_out should drive the bus |

## Verification
The hardest case to reach is a strobe during the commit window. A prefix broken partway is nearly as hard, because its bytes must vanish while the byte that breaks it is kept. The stimulus reaches the first case by waiting just past the byte timeout after a single write. It then makes two status reads and a stray write inside the commit. A third status read follows, and its toggle and low bits show that nothing moved. A separate phase starts with the first arming byte and breaks off. The array is then read at both the broken prefix address and the data address.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
    localparam int DATA_W = 8;

    // Command addresses at full 13-bit width; cut to ADDR_W in the top.
    localparam logic [12:0] CMD_ADDR_P = 13'h1555;
    localparam logic [12:0] CMD_ADDR_Q = 13'h0AAA;

    localparam logic [DATA_W-1:0] CB_LEAD   = 8'hAA;
    localparam logic [DATA_W-1:0] CB_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] CB_ARM    = 8'hA0;
    localparam logic [DATA_W-1:0] CB_EXT    = 8'h80;
    localparam logic [DATA_W-1:0] CB_FREE   = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROGRAM
    } ctl_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GOT1,
        SQ_GOT2,
        SQ_GOT3,
        SQ_GOT4,
        SQ_GOT5,
        SQ_DATA
    } seq_e;
endpackage

// File: rtl/eepc_seq_detect.sv
module eepc_seq_detect
    import eepc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_load,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              is_cmd,
    output logic              arm_hit,
    output logic              release_hit
);
    localparam logic [ADDR_W-1:0] AP = CMD_ADDR_P[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] AQ = CMD_ADDR_Q[ADDR_W-1:0];

    seq_e step_q, step_d, cur;
    logic at_p, at_q;

    assign at_p = (addr == AP);
    assign at_q = (addr == AQ);
    assign cur  = in_load ? step_q : SQ_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n)        step_q <= SQ_IDLE;
        else if (strobe)   step_q <= step_d;
        else if (!in_load) step_q <= SQ_IDLE;
    end

    always_comb begin
        step_d      = SQ_DATA;
        is_cmd      = 1'b0;
        arm_hit     = 1'b0;
        release_hit = 1'b0;
        unique case (cur)
            SQ_IDLE, SQ_GOT3: begin
                if (at_p && data == CB_LEAD) begin
                    step_d = (cur == SQ_IDLE) ? SQ_GOT1 : SQ_GOT4;
                    is_cmd = 1'b1;
                end
            end
            SQ_GOT1, SQ_GOT4: begin
                if (at_q && data == CB_SECOND) begin
                    step_d = (cur == SQ_GOT1) ? SQ_GOT2 : SQ_GOT5;
                    is_cmd = 1'b1;
                end
            end
            SQ_GOT2: begin
                if (at_p && data == CB_ARM) begin
                    is_cmd  = 1'b1;
                    arm_hit = 1'b1;
                end else if (at_p && data == CB_EXT) begin
                    step_d = SQ_GOT3;
                    is_cmd = 1'b1;
                end
            end
            SQ_GOT5: begin
                if (at_p && data == CB_FREE) begin
                    is_cmd      = 1'b1;
                    release_hit = 1'b1;
                end
            end
            SQ_DATA: step_d = SQ_DATA;
            default: step_d = SQ_DATA;
        endcase
    end

    // R5
    arm_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && arm_hit) |-> in_load);

    // R7
    release_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && release_hit) |-> in_load);

    // R9
    abandon_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !is_cmd) |=> (step_q == SQ_DATA));
endmodule

// File: rtl/eepc_page_buf.sv
module eepc_page_buf
    import eepc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr,
    input  logic                     lock,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data,
    input  logic [PAGE_W-1:0]        rd_idx,
    output logic [ADDR_W-PAGE_W-1:0] page,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);
    localparam int NB   = 1 << PAGE_W;
    localparam int PG_W = ADDR_W - PAGE_W;

    logic [DATA_W-1:0] store_q [NB];
    logic [NB-1:0]     valid_q, valid_d;
    logic [PG_W-1:0]   page_q, in_page;
    logic [PAGE_W-1:0] off;
    logic              has_q, fresh, accept;

    assign in_page = addr[ADDR_W-1:PAGE_W];
    assign off     = addr[PAGE_W-1:0];
    assign fresh   = clear || !has_q;
    assign accept  = wr && !lock && (fresh || in_page == page_q);

    always_comb begin
        valid_d = clear ? '0 : valid_q;
        if (accept) valid_d[off] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            has_q   <= 1'b0;
            page_q  <= '0;
        end else begin
            valid_q <= valid_d;
            if (clear)  has_q <= 1'b0;
            if (accept) begin
                has_q <= 1'b1;
                if (fresh) page_q <= in_page;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) store_q[off] <= data;
    end

    assign page     = page_q;
    assign rd_data  = store_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // R3
    frozen_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(valid_q));

    // R2
    foreign_page_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clear && has_q && in_page != page_q) |=> $stable(valid_q));
endmodule

// File: rtl/eepc_ctrl.sv
module eepc_ctrl
    import eepc_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int LOAD_TIMEOUT = 20,
    parameter int WRITE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int TMR_MAX    = (LOAD_TIMEOUT > WRITE_CYCLES) ? LOAD_TIMEOUT : WRITE_CYCLES;
    localparam int TW         = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] LT_LAST = TW'(LOAD_TIMEOUT - 1);
    localparam logic [TW-1:0] WC_LAST = TW'(WRITE_CYCLES - 1);
    localparam logic [TW-1:0] PB_LIM  = TW'(PAGE_BYTES);

    ctl_e              state_q, state_d;
    logic [TW-1:0]     tmr_q;
    logic              we_q, rd_q, prot_q, arm_seen_q, rel_seen_q, toggle_q;
    logic [DATA_W-1:0] last_q;
    logic [DATA_W-1:0] mem [DEPTH];

    logic strobe, strobe_acc, busy, in_load, phase_start, rd_now, rd_end;
    logic is_cmd, arm_hit, release_hit, commit_ok, mem_we, tmr_end;
    logic [PG_W-1:0]   pb_page;
    logic [DATA_W-1:0] pb_data;
    logic              pb_valid;
    logic [PAGE_W-1:0] commit_idx;

    assign strobe      = !ce_n && !we_n && we_q;
    assign busy        = (state_q == ST_PROGRAM);
    assign in_load     = (state_q == ST_LOAD);
    assign strobe_acc  = strobe && !busy;
    assign phase_start = strobe_acc && (state_q == ST_IDLE);
    assign rd_now      = !ce_n && !oe_n && we_n;
    assign rd_end      = rd_q && !rd_now;
    assign commit_idx  = tmr_q[PAGE_W-1:0];
    assign tmr_end     = busy && (tmr_q == WC_LAST);
    assign commit_ok   = !prot_q || arm_seen_q || rel_seen_q;
    assign mem_we      = busy && (tmr_q < PB_LIM) && pb_valid && commit_ok;

    eepc_seq_detect #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_load     (in_load),
        .strobe      (strobe_acc),
        .addr        (addr),
        .data        (din),
        .is_cmd      (is_cmd),
        .arm_hit     (arm_hit),
        .release_hit (release_hit)
    );

    eepc_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (phase_start),
        .wr       (strobe_acc && !is_cmd),
        .lock     (busy),
        .addr     (addr),
        .data     (din),
        .rd_idx   (commit_idx),
        .page     (pb_page),
        .rd_data  (pb_data),
        .rd_valid (pb_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: phase_open, byte_reload, load_expire, commit_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (strobe_acc) state_d = ST_LOAD;
            ST_LOAD:    if (!strobe_acc && tmr_q == LT_LAST) state_d = ST_PROGRAM;
            ST_PROGRAM: if (tmr_q == WC_LAST) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Timer, phase flags, lock and status byte sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q      <= '0;
            we_q       <= 1'b1;
            rd_q       <= 1'b0;
            prot_q     <= 1'b0;
            arm_seen_q <= 1'b0;
            rel_seen_q <= 1'b0;
            toggle_q   <= 1'b0;
            last_q     <= '0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_now;
            if (state_d != state_q || state_q == ST_IDLE || strobe_acc) tmr_q <= '0;
            else                                                        tmr_q <= tmr_q + 1'b1;
            if (phase_start) begin
                arm_seen_q <= arm_hit;
                rel_seen_q <= release_hit;
            end else if (strobe_acc) begin
                arm_seen_q <= arm_seen_q | arm_hit;
                rel_seen_q <= rel_seen_q | release_hit;
            end
            if (tmr_end) begin
                if (rel_seen_q)      prot_q <= 1'b0;
                else if (arm_seen_q) prot_q <= 1'b1;
            end
            if (in_load && state_d == ST_PROGRAM) toggle_q <= 1'b0;
            else if (busy && rd_end)              toggle_q <= ~toggle_q;
            if (strobe_acc && !is_cmd) last_q <= din;
        end
    end

    // Read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= rd_now;
            dq_out <= busy ? {~last_q[7], toggle_q, last_q[5:0]} : mem[addr];
        end
    end

    // Serial commit of the page buffer, one offset per cycle
    always_ff @(posedge clk) begin
        if (mem_we) mem[{pb_page, commit_idx}] <= pb_data;
    end

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dq_oe);

    // R3
    commit_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_PROGRAM) |-> (tmr_q == '0));

    // R3
    no_skip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_PROGRAM));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PROGRAM) |=> $stable(prot_q));
endmodule

// File: tb/eepc_ctrl_bench.sv
`timescale 1ns/100ps
module eepc_ctrl_bench;
    localparam int AW = 11;
    localparam int LT = 20;
    localparam int WC = 100;
    localparam logic [1:0] OP_WR = 2'd0, OP_END = 2'd1, OP_RD = 2'd2, OP_WT = 2'd3;
    localparam int NV = 58;

    // {op, requirement, address, data}
    localparam logic [24:0] VEC [NV] = '{
        {OP_WR, 4'd2, 11'h080, 8'h5A}, {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_WR, 4'd8, 11'h555, 8'h0F}, {OP_END, 4'd0, 11'h000, 8'h00},   // R8 preload
        {OP_WR, 4'd8, 11'h2AA, 8'hF0}, {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_WR, 4'd2, 11'h040, 8'h11}, {OP_WR, 4'd2, 11'h041, 8'h22},     // R2 page load
        {OP_WR, 4'd2, 11'h07F, 8'h33}, {OP_WR, 4'd2, 11'h080, 8'h44},     // foreign page
        {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_RD, 4'd1, 11'h040, 8'h11}, {OP_RD, 4'd2, 11'h041, 8'h22},     // R1
        {OP_RD, 4'd2, 11'h07F, 8'h33}, {OP_RD, 4'd2, 11'h080, 8'h5A},
        {OP_WR, 4'd4, 11'h100, 8'hC6}, {OP_WT, 4'd0, 11'h000, 8'h00},     // R4 polling
        {OP_RD, 4'd4, 11'h100, 8'h06}, {OP_RD, 4'd4, 11'h100, 8'h46},
        {OP_WR, 4'd3, 11'h100, 8'h99}, {OP_RD, 4'd3, 11'h100, 8'h06},     // R3 stray strobe
        {OP_END, 4'd0, 11'h000, 8'h00}, {OP_RD, 4'd3, 11'h100, 8'hC6},
        {OP_WR, 4'd5, 11'h555, 8'hAA}, {OP_WR, 4'd5, 11'h2AA, 8'h55},     // R5 arm
        {OP_WR, 4'd5, 11'h555, 8'hA0}, {OP_WR, 4'd5, 11'h140, 8'h77},
        {OP_END, 4'd0, 11'h000, 8'h00}, {OP_RD, 4'd5, 11'h140, 8'h77},
        {OP_RD, 4'd8, 11'h555, 8'h0F}, {OP_RD, 4'd8, 11'h2AA, 8'hF0},
        {OP_WR, 4'd6, 11'h140, 8'h99}, {OP_END, 4'd0, 11'h000, 8'h00},   // R6 locked
        {OP_RD, 4'd6, 11'h140, 8'h77},
        {OP_WR, 4'd5, 11'h555, 8'hAA}, {OP_WR, 4'd5, 11'h2AA, 8'h55},
        {OP_WR, 4'd5, 11'h555, 8'hA0}, {OP_WR, 4'd5, 11'h141, 8'h88},
        {OP_END, 4'd0, 11'h000, 8'h00}, {OP_RD, 4'd5, 11'h141, 8'h88},
        {OP_WR, 4'd7, 11'h555, 8'hAA}, {OP_WR, 4'd7, 11'h2AA, 8'h55},     // R7 release
        {OP_WR, 4'd7, 11'h555, 8'h80}, {OP_WR, 4'd7, 11'h555, 8'hAA},
        {OP_WR, 4'd7, 11'h2AA, 8'h55}, {OP_WR, 4'd7, 11'h555, 8'h20},
        {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_WR, 4'd7, 11'h140, 8'h12}, {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_RD, 4'd7, 11'h140, 8'h12},
        {OP_WR, 4'd9, 11'h555, 8'hAA}, {OP_WR, 4'd9, 11'h180, 8'h3C},     // R9 abandon
        {OP_END, 4'd0, 11'h000, 8'h00},
        {OP_RD, 4'd9, 11'h180, 8'h3C}, {OP_RD, 4'd9, 11'h555, 8'h0F},
        {OP_WR, 4'd8, 11'h555, 8'h66}, {OP_END, 4'd0, 11'h000, 8'h00},   // R8 reuse
        {OP_RD, 4'd8, 11'h555, 8'h66}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;
    int            n_chk = 0, n_bad = 0;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    eepc_ctrl #(.ADDR_W(AW), .PAGE_W(6), .LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)) u_eepc_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_byte(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic rd_check(input int req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       oe;
        rd_byte(a, d, oe);
        check(req, {7'd0, oe}, 8'd1);
        check(req, d, exp);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got hang expected finish");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R10: after reset nothing drives the bus
        check(10, {7'd0, dq_oe}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            case (v[24:23])
                OP_WR:  wr_byte(v[18:8], v[7:0]);
                OP_END: wait_cyc(LT + WC + 8);
                OP_WT:  wait_cyc(LT + 4);
                OP_RD:  rd_check(int'(v[22:19]), v[18:8], v[7:0]);
                default: ;
            endcase
        end

        // R3: the byte timer restarts on each strobe, so a foreign-page byte
        // inside the window is dropped instead of opening a new phase
        wr_byte(11'h200, 8'hAB);
        wait_cyc(LT + WC + 8);
        wr_byte(11'h1C0, 8'h01);
        wait_cyc(LT - 6);
        wr_byte(11'h200, 8'h02);
        wait_cyc(LT + WC + 8);
        rd_check(3, 11'h200, 8'hAB);
        rd_check(3, 11'h1C0, 8'h01);

        // R10: reset drops an armed lock
        wr_byte(11'h555, 8'hAA);
        wr_byte(11'h2AA, 8'h55);
        wr_byte(11'h555, 8'hA0);
        wait_cyc(LT + WC + 8);
        do_reset();
        check(10, {7'd0, dq_oe}, 8'd0);
        wr_byte(11'h240, 8'h5C);
        wait_cyc(LT + WC + 8);
        rd_check(10, 11'h240, 8'h5C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule